// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block sits in the always-on domain and runs from the slow clock. It controls a supply-voltage comparator, which is modelled here as a digital below-threshold input. The controller can keep the comparator powered all the time. It can also power the comparator for a single slow-clock cycle in every 32, 256 or 2048 cycles, which cuts the average monitor current. It can also leave the comparator off.

Each time the comparator is powered, the controller captures its output at the clock edge that ends the enable cycle. A captured below-threshold result counts as a detection. A detection updates a live status bit and sets a sticky status bit. The sticky bit holds until software reads the status, and it drives an interrupt when the interrupt is enabled. When a detection first appears, the block issues a one-cycle core reset request and a one-cycle core wake-up request. Each request has its own enable.

Software writes a mode word that holds the sample period, the reset enable and the interrupt enable. It writes a separate wake-up word that holds the wake-up enable. A status-read strobe marks a read of the status word.

Top module: `vmon_duty_ctrl`

## Requirements
- R1: After reset, `mon_en`, `stat_live`, `stat_sticky`, `irq`, `core_rst_req` and `core_wake_req` are all 0. The stored sample period is 0 (off), and every stored enable is 0.
- R2: When the stored sample period is 0, or any value from 5 to 7, `mon_en` stays 0 and no sample is taken.
- R3: A sample period of 1 selects continuous mode. In continuous mode `mon_en` is 1 in every cycle, and the comparator is sampled at every clock edge.
- R4: Sample periods 2, 3 and 4 select intervals of 32, 256 and 2048 cycles. Every write to the mode word restarts the interval. With interval N, `mon_en` is first 1 in the Nth cycle after the write edge, stays 1 for exactly that one cycle, and then repeats every N cycles.
- R5: `cmp_below` has no effect on any output while `mon_en` is 0.
- R6: `stat_live` takes the value of `cmp_below` at each edge that ends a cycle in which `mon_en` is 1, and it holds that value at every other edge.
- R7: `stat_sticky` is set by any sampled detection and cleared by `stat_rd`. If a detection and `stat_rd` arrive in the same cycle, `stat_sticky` stays set.
- R8: `irq` equals `stat_sticky` AND the stored interrupt enable.
- R9: When the reset enable is 1, a detection sampled while `stat_live` is 0 produces a one-cycle `core_rst_req` pulse in the cycle after the sampling edge. Repeated detections produce no further pulse.
- R10: When the wake-up enable is 1, the same rising detection produces a one-cycle `core_wake_req` pulse, independent of the reset enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_period | input | 3 | Sample period code: 0 off, 1 continuous, 2/3/4 for 32/256/2048 |
| mode_rst_en | input | 1 | Reset-request enable written with the mode word |
| mode_irq_en | input | 1 | Interrupt enable written with the mode word |
| wake_wr | input | 1 | Write strobe for the wake-up word |
| wake_en | input | 1 | Wake-up-request enable |
| stat_rd | input | 1 | Status-read strobe; clears the sticky bit |
| cmp_below | input | 1 | Comparator output, 1 when the supply is below threshold |
| mon_en | output | 1 | Comparator power enable |
| stat_live | output | 1 | Last sampled comparator result |
| stat_sticky | output | 1 | Detection seen since the last status read |
| irq | output | 1 | Interrupt request |
| core_rst_req | output | 1 | One-cycle core reset request |
| core_wake_req | output | 1 | One-cycle core wake-up request |

## Verification
An interval counter that drifts shows at `mon_en` within one interval. It appears as a pulse one cycle early or late after a mode write, or as a second enable cycle. The bench watches every cycle of each interval, so the error is caught on the first period. A wrong sample gate lets `cmp_below` reach `stat_live` or `stat_sticky` during disabled cycles, and this shows on the very next edge. A wrong edge detector or a wrong clear priority shows as a missing, doubled or ungated request pulse, or as a lost sticky bit, one cycle after the detection that triggers it.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

    // Sample period codes stored in the mode word
    localparam logic [2:0] PER_OFF  = 3'd0;
    localparam logic [2:0] PER_CONT = 3'd1;
    localparam logic [2:0] PER_S    = 3'd2;
    localparam logic [2:0] PER_M    = 3'd3;
    localparam logic [2:0] PER_L    = 3'd4;

    typedef enum logic [1:0] {
        RUN_OFF  = 2'd0,
        RUN_CONT = 2'd1,
        RUN_PER  = 2'd2
    } run_mode_e;

    typedef struct packed {
        logic [2:0] period;
        logic       rst_en;
        logic       irq_en;
        logic       wake_en;
    } vmon_cfg_t;

    function automatic run_mode_e decode_run(input logic [2:0] code);
        case (code)
            PER_CONT:           return RUN_CONT;
            PER_S, PER_M, PER_L: return RUN_PER;
            default:            return RUN_OFF;
        endcase
    endfunction

endpackage

// File: rtl/vmon_timer.sv
module vmon_timer
    import vmon_pkg::*;
#(
    parameter int unsigned INT_S = 32,
    parameter int unsigned INT_M = 256,
    parameter int unsigned INT_L = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] period,
    input  logic       restart,
    output logic       mon_en
);
    localparam int unsigned CNT_W = $clog2(INT_L);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(INT_S - 1);
    localparam logic [CNT_W-1:0] LIM_M = CNT_W'(INT_M - 1);
    localparam logic [CNT_W-1:0] LIM_L = CNT_W'(INT_L - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    run_mode_e        run;

    always_comb begin
        run = decode_run(period);
        case (period)
            PER_S:   limit = LIM_S;
            PER_M:   limit = LIM_M;
            default: limit = LIM_L;
        endcase

        mon_en = (run == RUN_CONT) || ((run == RUN_PER) && (cnt_q == limit));

        if (restart || (run != RUN_PER) || (cnt_q == limit)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Periodic enable lasts a single cycle unless the interval is restarted
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((run == RUN_PER) && mon_en && !restart) |=> !mon_en);

endmodule

// File: rtl/vmon_status.sv
module vmon_status (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic below,
    input  logic rd,
    input  logic rst_en,
    input  logic wake_en,
    output logic live,
    output logic sticky,
    output logic rst_req,
    output logic wake_req
);
    typedef struct packed {
        logic live;
        logic sticky;
        logic rst_req;
        logic wake_req;
    } stat_t;

    stat_t st_d, st_q;
    logic  det;
    logic  rise;

    always_comb begin
        det  = sample && below;
        rise = det && !st_q.live;

        st_d          = st_q;
        st_d.live     = sample ? below : st_q.live;
        st_d.sticky   = det || (st_q.sticky && !rd);
        st_d.rst_req  = rise && rst_en;
        st_d.wake_req = rise && wake_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live     = st_q.live;
    assign sticky   = st_q.sticky;
    assign rst_req  = st_q.rst_req;
    assign wake_req = st_q.wake_req;

    assert_live_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(live));

    assert_sticky_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !rd) |=> sticky);

    assert_rst_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_wake_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (live && sticky));

endmodule

// File: rtl/vmon_duty_ctrl.sv
module vmon_duty_ctrl
    import vmon_pkg::*;
#(
    parameter int unsigned INT_S = 32,
    parameter int unsigned INT_M = 256,
    parameter int unsigned INT_L = 2048
) (
    input  logic       clk_slow,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_period,
    input  logic       mode_rst_en,
    input  logic       mode_irq_en,
    input  logic       wake_wr,
    input  logic       wake_en,
    input  logic       stat_rd,
    input  logic       cmp_below,
    output logic       mon_en,
    output logic       stat_live,
    output logic       stat_sticky,
    output logic       irq,
    output logic       core_rst_req,
    output logic       core_wake_req
);
    vmon_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr) begin
            cfg_d.period = mode_period;
            cfg_d.rst_en = mode_rst_en;
            cfg_d.irq_en = mode_irq_en;
        end
        if (wake_wr) begin
            cfg_d.wake_en = wake_en;
        end
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    vmon_timer #(
        .INT_S (INT_S),
        .INT_M (INT_M),
        .INT_L (INT_L)
    ) u_timer (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .period  (cfg_q.period),
        .restart (mode_wr),
        .mon_en  (mon_en)
    );

    vmon_status u_status (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .sample   (mon_en),
        .below    (cmp_below),
        .rd       (stat_rd),
        .rst_en   (cfg_q.rst_en),
        .wake_en  (cfg_q.wake_en),
        .live     (stat_live),
        .sticky   (stat_sticky),
        .rst_req  (core_rst_req),
        .wake_req (core_wake_req)
    );

    assign irq = stat_sticky && cfg_q.irq_en;

    assert_off_quiet_R2: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (decode_run(cfg_q.period) == RUN_OFF) |-> !mon_en);

    assert_cont_on_R3: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (cfg_q.period == PER_CONT) |-> mon_en);

    assert_no_req_unsampled_R5: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !mon_en |=> (!core_rst_req && !core_wake_req));

endmodule

// File: tb/vmon_duty_ctrl_test.sv
module vmon_duty_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk_slow = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_period = 3'd0;
    logic       mode_rst_en = 1'b0;
    logic       mode_irq_en = 1'b0;
    logic       wake_wr = 1'b0;
    logic       wake_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       cmp_below = 1'b0;
    logic       mon_en, stat_live, stat_sticky, irq, core_rst_req, core_wake_req;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk_slow = ~clk_slow;

    vmon_duty_ctrl uut (
        .clk_slow      (clk_slow),
        .rst_n         (rst_n),
        .mode_wr       (mode_wr),
        .mode_period   (mode_period),
        .mode_rst_en   (mode_rst_en),
        .mode_irq_en   (mode_irq_en),
        .wake_wr       (wake_wr),
        .wake_en       (wake_en),
        .stat_rd       (stat_rd),
        .cmp_below     (cmp_below),
        .mon_en        (mon_en),
        .stat_live     (stat_live),
        .stat_sticky   (stat_sticky),
        .irq           (irq),
        .core_rst_req  (core_rst_req),
        .core_wake_req (core_wake_req)
    );

    // Continuous-mode vectors: {below, rd, exp_live, exp_sticky, exp_rst, exp_wake}
    localparam logic [5:0] VEC [10] = '{
        6'b00_0000,
        6'b10_1111,
        6'b10_1100,
        6'b11_1100,
        6'b01_0000,
        6'b00_0000,
        6'b10_1111,
        6'b00_0100,
        6'b01_0000,
        6'b10_1111
    };

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_slow);
        #1;
    endtask

    task automatic write_mode(input logic [2:0] per, input logic re, input logic ie);
        mode_wr = 1'b1; mode_period = per; mode_rst_en = re; mode_irq_en = ie;
        tick();
        mode_wr = 1'b0;
    endtask

    // Clear live and sticky state in continuous mode with rst/wake as given
    task automatic clear_state();
        write_mode(3'd1, mode_rst_en, mode_irq_en);
        cmp_below = 1'b0; stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    // Periodic interval check for code per, interval n
    task automatic run_interval(input logic [2:0] per, input int n, input string tag);
        clear_state();
        write_mode(per, 1'b1, 1'b1);
        cmp_below = 1'b1;
        for (int m = 0; m <= n; m++) begin
            if (m < n) begin
                chk(tag, "mon_en timing", mon_en, (m == n - 1));
                chk("R5", "sticky before sample", stat_sticky, 1'b0);
                tick();
            end else begin
                chk(tag, "live after sample", stat_live, 1'b1);
                chk("R7", "sticky after sample", stat_sticky, 1'b1);
                chk("R9", "rst pulse after sample", core_rst_req, 1'b1);
                chk(tag, "enable dropped", mon_en, 1'b0);
            end
        end
        tick();
        chk("R9", "rst pulse one cycle", core_rst_req, 1'b0);
        // Second pulse arrives one full interval after the first
        for (int m = 1; m < n; m++) begin
            chk(tag, "second interval", mon_en, (m == n - 1));
            tick();
        end
        cmp_below = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        // R1: reset state
        chk("R1", "mon_en", mon_en, 1'b0);
        chk("R1", "live", stat_live, 1'b0);
        chk("R1", "sticky", stat_sticky, 1'b0);
        chk("R1", "irq", irq, 1'b0);
        chk("R1", "rst_req", core_rst_req, 1'b0);
        chk("R1", "wake_req", core_wake_req, 1'b0);
        rst_n = 1'b1;
        cmp_below = 1'b1;
        tick();
        tick();
        chk("R1", "off after reset ignores below", stat_sticky, 1'b0);
        cmp_below = 1'b0;

        // Continuous table walk: R3, R6, R7, R8, R9, R10
        wake_wr = 1'b1; wake_en = 1'b1;
        write_mode(3'd1, 1'b1, 1'b1);
        wake_wr = 1'b0;
        for (int i = 0; i < 10; i++) begin
            cmp_below = VEC[i][5];
            stat_rd   = VEC[i][4];
            chk("R3", "continuous enable", mon_en, 1'b1);
            tick();
            chk("R6", "live", stat_live, VEC[i][3]);
            chk("R7", "sticky", stat_sticky, VEC[i][2]);
            chk("R8", "irq", irq, VEC[i][2]);
            chk("R9", "rst_req", core_rst_req, VEC[i][1]);
            chk("R10", "wake_req", core_wake_req, VEC[i][0]);
        end
        stat_rd = 1'b0;

        // Off modes: code 0 and code 7 (R2, R5)
        clear_state();
        write_mode(3'd0, 1'b1, 1'b1);
        cmp_below = 1'b1;
        for (int k = 0; k < 40; k++) begin
            chk("R2", "off code 0", mon_en, 1'b0);
            tick();
        end
        chk("R5", "live untouched", stat_live, 1'b0);
        chk("R5", "sticky untouched", stat_sticky, 1'b0);
        write_mode(3'd7, 1'b1, 1'b1);
        for (int k = 0; k < 40; k++) begin
            chk("R2", "off code 7", mon_en, 1'b0);
            tick();
        end
        chk("R5", "no request", core_rst_req | core_wake_req, 1'b0);
        chk("R5", "sticky untouched code 7", stat_sticky, 1'b0);
        cmp_below = 1'b0;

        // Periodic intervals (R4)
        run_interval(3'd2, 32, "R4");
        run_interval(3'd3, 256, "R4");
        run_interval(3'd4, 2048, "R4");

        // Enable gating: wake only, irq disabled (R8, R10)
        clear_state();
        write_mode(3'd1, 1'b0, 1'b0);
        cmp_below = 1'b1;
        tick();
        chk("R10", "wake without rst", core_wake_req, 1'b1);
        chk("R9", "rst gated off", core_rst_req, 1'b0);
        chk("R8", "irq gated off", irq, 1'b0);
        chk("R7", "sticky still set", stat_sticky, 1'b1);

        // Reset only, wake disabled (R9, R10)
        cmp_below = 1'b0;
        wake_wr = 1'b1; wake_en = 1'b0;
        write_mode(3'd1, 1'b1, 1'b1);
        wake_wr = 1'b0;
        chk("R8", "irq follows enable", irq, 1'b1);
        cmp_below = 1'b1;
        tick();
        chk("R9", "rst with wake off", core_rst_req, 1'b1);
        chk("R10", "wake gated off", core_wake_req, 1'b0);
        cmp_below = 1'b0;
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule